// File: doc/BRIEF.md
# Operand Effective-Address Decoder (32-bit addressing)

This block turns the operand-specifier byte of an instruction (the ModR/M byte), an optional scale-index-base (SIB) byte, a raw displacement word and a snapshot of the eight 32-bit general registers into a complete operand description. It reports the register/opcode-extension field. It says whether the operand is a register or a memory location. It also reports how many displacement bytes the instruction stream carries, whether a SIB byte is required and, for memory operands, the computed effective address. When the scale-index encoding is not defined, it raises a flag.

A front end presents the bytes it has fetched together with `in_valid`. The caller always hands over a full 32-bit displacement word, and the block uses only as much of it as the addressing form calls for. All results are registered and appear one cycle after `in_valid` with `out_valid`. They hold their values until the next accepted decode. Fetching bytes, prefixes, opcodes, segmentation and the 16-bit addressing forms are handled elsewhere.

Top module: `operand_ea_decoder`

## Requirements
- R1: `reg_field` equals bits 5:3 of the ModR/M byte accepted on the previous `in_valid` cycle.
- R2: When ModR/M bits 7:6 are 11, `is_reg_direct` is 1, `rm_reg` equals ModR/M bits 2:0, and `eff_addr`, `disp_bytes`, `needs_sib` and `addr_undef` are all 0. For memory forms, `is_reg_direct` and `rm_reg` are 0.
- R3: For a memory form, the displacement length follows ModR/M bits 7:6. Code 00 gives `disp_bytes`=0, and the displacement word is ignored (except in R4/R7). Code 01 gives `disp_bytes`=1 and adds the sign-extended low byte of `disp_word`. Code 10 gives `disp_bytes`=4 and adds the whole `disp_word`.
- R4: ModR/M bits 7:6 = 00 with bits 2:0 = 101 is displacement-only. In that case `eff_addr` = `disp_word`, `disp_bytes`=4 and no register is added.
- R5: ModR/M bits 2:0 = 100 in a memory form sets `needs_sib`. The address is then base + (index << ss) + displacement, where ss is SIB bits 7:6, index is SIB bits 5:3 and base is SIB bits 2:0.
- R6: A SIB index code of 100 adds no index term. In that case `addr_undef` is 1 exactly when ss is not 00. Otherwise `addr_undef` is 0.
- R7: A SIB base code of 101 with ModR/M bits 7:6 = 00 adds no base register and takes a 32-bit displacement (`disp_bytes`=4). With ModR/M bits 7:6 = 01 or 10, base code 101 selects register 5 as normal.
- R8: `out_valid` is 1 exactly in the cycle after an `in_valid` cycle. When `in_valid` is 0, every other output keeps its value.
- R9: After reset, all outputs are 0.
- R10: Register codes 0..7 select slices `gpr_flat[32*k +: 32]` (0 EAX, 1 ECX, 2 EDX, 3 EBX, 4 ESP, 5 EBP, 6 ESI, 7 EDI). Code 4 is valid as a SIB base.
- R11: The effective-address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry a decode request this cycle |
| modrm_byte | input | 8 | Operand-specifier byte |
| sib_byte | input | 8 | Scale-index-base byte (used only when required) |
| disp_word | input | 32 | Raw displacement, low byte used for 8-bit form |
| gpr_flat | input | 256 | Eight 32-bit registers, register k at bits 32k+31:32k |
| out_valid | output | 1 | Results below belong to the last accepted request |
| reg_field | output | 3 | Register / opcode-extension field |
| is_reg_direct | output | 1 | Operand is a register, no memory address |
| rm_reg | output | 3 | Register number of a register-direct operand |
| disp_bytes | output | 3 | Displacement bytes consumed: 0, 1 or 4 |
| needs_sib | output | 1 | A SIB byte belongs to this operand |
| eff_addr | output | 32 | Computed effective address |
| addr_undef | output | 1 | Scaled no-index encoding, address undefined |

## Verification
The assertions assume that `in_valid` is held low while reset is asserted. They also assume that the other inputs carry meaningful bytes only in cycles where `in_valid` is high. The SIB byte and displacement may be arbitrary when the form does not use them. The stimulus changes inputs only on the falling edge. It holds `in_valid` low through reset and between requests. It deliberately places garbage in unused SIB and displacement inputs, so that the ignored-input cases are exercised under those assumptions.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [1:0] MD_NODISP = 2'b00;
  localparam logic [1:0] MD_D8     = 2'b01;
  localparam logic [1:0] MD_D32    = 2'b10;
  localparam logic [1:0] MD_REG    = 2'b11;
  localparam logic [2:0] CODE_ESC    = 3'b100;
  localparam logic [2:0] CODE_NOBASE = 3'b101;

  typedef enum logic [1:0] {DSP_NONE, DSP_B8, DSP_W32} disp_kind_e;

  typedef struct packed {
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;
  } modrm_t;

  typedef struct packed {
    logic [1:0] scale;
    logic [2:0] idx;
    logic [2:0] bse;
  } sib_t;

  function automatic logic [2:0] disp_len(disp_kind_e k);
    case (k)
      DSP_B8:  return 3'd1;
      DSP_W32: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
  import ea_pkg::*;
(
  input  logic [7:0]  modrm_i,
  input  logic [7:0]  sib_i,
  output logic [2:0]  reg_o,
  output logic [2:0]  rm_o,
  output logic        reg_direct_o,
  output logic        sib_used_o,
  output logic        base_absent_o,
  output logic        idx_absent_o,
  output logic [1:0]  scale_o,
  output logic [2:0]  base_sel_o,
  output logic [2:0]  idx_sel_o,
  output disp_kind_e  disp_kind_o
);
  modrm_t m;
  sib_t   s;
  logic   nobase_code;

  assign m = modrm_i;
  assign s = sib_i;

  always_comb begin
    reg_o        = m.rg;
    rm_o         = m.rm;
    reg_direct_o = (m.md == MD_REG);
    sib_used_o   = !reg_direct_o && (m.rm == CODE_ESC);
    base_sel_o   = sib_used_o ? s.bse : m.rm;
    idx_sel_o    = s.idx;
    scale_o      = s.scale;
    idx_absent_o = !sib_used_o || (s.idx == CODE_ESC);
    nobase_code  = sib_used_o ? (s.bse == CODE_NOBASE) : (m.rm == CODE_NOBASE);
    base_absent_o = reg_direct_o || ((m.md == MD_NODISP) && nobase_code);
    case (m.md)
      MD_D8:     disp_kind_o = DSP_B8;
      MD_D32:    disp_kind_o = DSP_W32;
      MD_NODISP: disp_kind_o = nobase_code ? DSP_W32 : DSP_NONE;
      default:   disp_kind_o = DSP_NONE;
    endcase
  end
endmodule

// File: rtl/ea_reg_pick.sv
module ea_reg_pick #(
  parameter int XLEN  = 32,
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG*XLEN-1:0] regs_i,
  input  logic [IDX_W-1:0]     sel_i,
  output logic [XLEN-1:0]      val_o
);
  logic [XLEN-1:0] bank [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign bank[k] = regs_i[k*XLEN +: XLEN];
  end

  assign val_o = bank[sel_i];
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base_val_i,
  input  logic [XLEN-1:0] idx_val_i,
  input  logic [1:0]      scale_i,
  input  logic            base_absent_i,
  input  logic            idx_absent_i,
  input  disp_kind_e      disp_kind_i,
  input  logic [XLEN-1:0] disp_raw_i,
  output logic [XLEN-1:0] ea_o
);
  function automatic logic [XLEN-1:0] sext_byte(logic [7:0] b);
    return {{(XLEN-8){b[7]}}, b};
  endfunction

  function automatic logic [XLEN-1:0] scaled(logic [XLEN-1:0] v, logic [1:0] s);
    return v << s;
  endfunction

  logic [XLEN-1:0] base_term, idx_term, disp_term;

  always_comb begin
    base_term = base_absent_i ? '0 : base_val_i;
    idx_term  = idx_absent_i ? '0 : scaled(idx_val_i, scale_i);
    case (disp_kind_i)
      DSP_B8:  disp_term = sext_byte(disp_raw_i[7:0]);
      DSP_W32: disp_term = disp_raw_i;
      default: disp_term = '0;
    endcase
    ea_o = base_term + idx_term + disp_term;
  end
endmodule

// File: rtl/operand_ea_decoder.sv
module operand_ea_decoder
  import ea_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        modrm_byte,
  input  logic [7:0]        sib_byte,
  input  logic [XLEN-1:0]   disp_word,
  input  logic [8*XLEN-1:0] gpr_flat,
  output logic              out_valid,
  output logic [2:0]        reg_field,
  output logic              is_reg_direct,
  output logic [2:0]        rm_reg,
  output logic [2:0]        disp_bytes,
  output logic              needs_sib,
  output logic [XLEN-1:0]   eff_addr,
  output logic              addr_undef
);
  localparam int NUM_GPR = 8;
  localparam int IDX_W   = $clog2(NUM_GPR);

  logic [2:0]      f_reg, f_rm, base_sel, idx_sel;
  logic            reg_direct, sib_escape, base_absent, idx_absent;
  logic [1:0]      scale;
  disp_kind_e      disp_kind;
  logic [XLEN-1:0] base_val, idx_val, ea_nx;
  logic            undef_nx;

  ea_field_split u_split (
    .modrm_i      (modrm_byte),
    .sib_i        (sib_byte),
    .reg_o        (f_reg),
    .rm_o         (f_rm),
    .reg_direct_o (reg_direct),
    .sib_used_o   (sib_escape),
    .base_absent_o(base_absent),
    .idx_absent_o (idx_absent),
    .scale_o      (scale),
    .base_sel_o   (base_sel),
    .idx_sel_o    (idx_sel),
    .disp_kind_o  (disp_kind)
  );

  ea_reg_pick #(.XLEN(XLEN), .NREG(NUM_GPR), .IDX_W(IDX_W)) u_base_pick (
    .regs_i(gpr_flat), .sel_i(base_sel), .val_o(base_val)
  );

  ea_reg_pick #(.XLEN(XLEN), .NREG(NUM_GPR), .IDX_W(IDX_W)) u_idx_pick (
    .regs_i(gpr_flat), .sel_i(idx_sel), .val_o(idx_val)
  );

  ea_sum #(.XLEN(XLEN)) u_sum (
    .base_val_i   (base_val),
    .idx_val_i    (idx_val),
    .scale_i      (scale),
    .base_absent_i(base_absent),
    .idx_absent_i (idx_absent),
    .disp_kind_i  (disp_kind),
    .disp_raw_i   (disp_word),
    .ea_o         (ea_nx)
  );

  assign undef_nx = sib_escape && idx_absent && (scale != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      reg_field     <= '0;
      is_reg_direct <= 1'b0;
      rm_reg        <= '0;
      disp_bytes    <= '0;
      needs_sib     <= 1'b0;
      eff_addr      <= '0;
      addr_undef    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_field     <= f_reg;
        is_reg_direct <= reg_direct;
        rm_reg        <= reg_direct ? f_rm : 3'd0;
        disp_bytes    <= disp_len(disp_kind);
        needs_sib     <= sib_escape;
        eff_addr      <= reg_direct ? '0 : ea_nx;
        addr_undef    <= undef_nx;
      end
    end
  end
endmodule

// File: rtl/ea_decode_checker.sv
module ea_decode_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [7:0]      modrm_byte,
  input logic            out_valid,
  input logic [2:0]      reg_field,
  input logic            is_reg_direct,
  input logic [2:0]      rm_reg,
  input logic [2:0]      disp_bytes,
  input logic            needs_sib,
  input logic [XLEN-1:0] eff_addr,
  input logic            addr_undef
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(eff_addr) && $stable(reg_field) && $stable(disp_bytes)); // R8
  AST_REG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> reg_field == $past(modrm_byte[5:3])); // R1
  AST_DIRECT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] == 2'b11 |=>
      is_reg_direct && rm_reg == $past(modrm_byte[2:0]) && eff_addr == '0); // R2
  AST_DIRECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    is_reg_direct |-> disp_bytes == 3'd0 && !needs_sib && !addr_undef); // R2
  AST_DISP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_bytes == 3'd0 || disp_bytes == 3'd1 || disp_bytes == 3'd4); // R3
  AST_DISP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] == 2'b01 |=> disp_bytes == 3'd1); // R3
  AST_SIB_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] != 2'b11 && modrm_byte[2:0] == 3'b100 |=> needs_sib); // R5
  AST_UNDEF_SIB: assert property (@(posedge clk) disable iff (!rst_n)
    addr_undef |-> needs_sib); // R6
  AST_DISP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm_byte[7:6] == 2'b00 && modrm_byte[2:0] == 3'b101 |=>
      disp_bytes == 3'd4 && !needs_sib); // R4
endmodule

bind operand_ea_decoder ea_decode_checker #(.XLEN(XLEN)) u_ea_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm_byte(modrm_byte),
  .out_valid(out_valid), .reg_field(reg_field), .is_reg_direct(is_reg_direct),
  .rm_reg(rm_reg), .disp_bytes(disp_bytes), .needs_sib(needs_sib),
  .eff_addr(eff_addr), .addr_undef(addr_undef)
);

// File: tb/tb_operand_ea_decoder.sv
module tb_operand_ea_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  modrm_byte = '0;
  logic [7:0]  sib_byte = '0;
  logic [31:0] disp_word = '0;
  logic [255:0] gpr_flat;
  logic        out_valid, is_reg_direct, needs_sib, addr_undef;
  logic [2:0]  reg_field, rm_reg, disp_bytes;
  logic [31:0] eff_addr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] gv [8];

  always #10 clk = ~clk;

  operand_ea_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm_byte(modrm_byte),
    .sib_byte(sib_byte), .disp_word(disp_word), .gpr_flat(gpr_flat),
    .out_valid(out_valid), .reg_field(reg_field), .is_reg_direct(is_reg_direct),
    .rm_reg(rm_reg), .disp_bytes(disp_bytes), .needs_sib(needs_sib),
    .eff_addr(eff_addr), .addr_undef(addr_undef)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic decode(logic [7:0] m, logic [7:0] s, logic [31:0] d);
    @(negedge clk);
    modrm_byte = m; sib_byte = s; disp_word = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid after request", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R9 out_valid reset", {31'd0, out_valid}, 32'd0);
    chk("R9 eff_addr reset", eff_addr, 32'd0);
    chk("R9 flags reset", {26'd0, is_reg_direct, needs_sib, addr_undef, disp_bytes}, 32'd0);
  endtask

  task automatic t_reg_direct;
    decode(8'hD6, 8'hFF, 32'hFFFF_FFFF);
    chk("R1 reg field", {29'd0, reg_field}, 32'd2);
    chk("R2 direct flag", {31'd0, is_reg_direct}, 32'd1);
    chk("R2 rm_reg", {29'd0, rm_reg}, 32'd6);
    chk("R2 no address", eff_addr, 32'd0);
    chk("R2 no disp/sib/undef", {28'd0, needs_sib, disp_bytes}, 32'd0);
  endtask

  task automatic t_worked_case;
    decode(8'h04, 8'h4B, 32'hAAAA_AAAA);
    chk("R5 base+2*index", eff_addr, gv[3] + (gv[1] << 1));
    chk("R5 needs_sib", {31'd0, needs_sib}, 32'd1);
    chk("R3 mod00 no disp", {29'd0, disp_bytes}, 32'd0);
    chk("R2 memory form rm_reg zero", {28'd0, is_reg_direct, rm_reg}, 32'd0);
  endtask

  task automatic t_disp8_negative;
    decode(8'h59, 8'h00, 32'h1234_5680);
    chk("R3 disp8 len", {29'd0, disp_bytes}, 32'd1);
    chk("R3 disp8 sign-extended", eff_addr, gv[1] - 32'd128);
    chk("R1 reg field 3", {29'd0, reg_field}, 32'd3);
  endtask

  task automatic t_disp32_wrap;
    decode(8'h87, 8'h00, 32'h0000_0010);
    chk("R3 disp32 len", {29'd0, disp_bytes}, 32'd4);
    chk("R11 wraparound", eff_addr, 32'h0000_0000);
  endtask

  task automatic t_disp_only;
    decode(8'h0D, 8'hFF, 32'h1234_5678);
    chk("R4 disp-only address", eff_addr, 32'h1234_5678);
    chk("R4 disp-only len", {29'd0, disp_bytes}, 32'd4);
    chk("R4 no sib", {31'd0, needs_sib}, 32'd0);
  endtask

  task automatic t_mod00_ignores_disp;
    decode(8'h06, 8'hFF, 32'hDEAD_BEEF);
    chk("R3 mod00 disp ignored", eff_addr, gv[6]);
    chk("R3 mod00 len zero", {29'd0, disp_bytes}, 32'd0);
  endtask

  task automatic t_sib_nobase;
    decode(8'h04, 8'hB5, 32'h0000_0100);
    chk("R7 no base, scaled index + disp32", eff_addr, (gv[6] << 2) + 32'h100);
    chk("R7 disp len 4", {29'd0, disp_bytes}, 32'd4);
    decode(8'h44, 8'h05, 32'hFFFF_FF04);
    chk("R7 base 101 with mod01 uses EBP", eff_addr, gv[5] + gv[0] + 32'd4);
    chk("R7 mod01 len 1", {29'd0, disp_bytes}, 32'd1);
  endtask

  task automatic t_no_index;
    decode(8'h04, 8'h22, 32'h0);
    chk("R6 no index ss00 address", eff_addr, gv[2]);
    chk("R6 ss00 defined", {31'd0, addr_undef}, 32'd0);
    decode(8'h04, 8'hE2, 32'h0);
    chk("R6 no index ss11 undefined", {31'd0, addr_undef}, 32'd1);
    chk("R6 undefined still needs sib", {31'd0, needs_sib}, 32'd1);
    decode(8'h04, 8'hC3, 32'h0);
    chk("R6 real index ss11 defined", {31'd0, addr_undef}, 32'd0);
    chk("R5 scale by 8", eff_addr, gv[3] + (gv[0] << 3));
  endtask

  task automatic t_reg_numbering;
    for (int r = 0; r < 8; r++) begin
      if (r != 4) begin
        decode({2'b10, 3'b000, 3'(r)}, 8'h00, 32'h0);
        chk($sformatf("R10 register %0d as base", r), eff_addr, gv[r]);
      end
    end
    decode(8'h04, 8'h24, 32'h0);
    chk("R10 ESP as sib base", eff_addr, gv[4]);
  endtask

  task automatic t_hold;
    logic [31:0] prev;
    decode(8'h8A, 8'h00, 32'h0000_0003);
    prev = eff_addr;
    chk("R3 mod10 plus disp", prev, gv[2] + 32'd3);
    @(negedge clk);
    modrm_byte = 8'hC0; sib_byte = 8'h11; disp_word = 32'h5555_5555;
    @(negedge clk);
    @(negedge clk);
    chk("R8 out_valid low when idle", {31'd0, out_valid}, 32'd0);
    chk("R8 eff_addr held", eff_addr, prev);
    chk("R8 direct flag held", {31'd0, is_reg_direct}, 32'd0);
    chk("R8 reg_field held", {29'd0, reg_field}, 32'd1);
  endtask

  initial begin
    gv[0] = 32'h0000_1000; gv[1] = 32'h0000_0020; gv[2] = 32'h0003_0000;
    gv[3] = 32'h0040_0000; gv[4] = 32'h0500_0000; gv[5] = 32'h6000_0000;
    gv[6] = 32'h0000_0007; gv[7] = 32'hFFFF_FFF0;
    for (int k = 0; k < 8; k++) gpr_flat[k*32 +: 32] = gv[k];
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reg_direct;
    t_worked_case;
    t_disp8_negative;
    t_disp32_wrap;
    t_disp_only;
    t_mod00_ignores_disp;
    t_sib_nobase;
    t_no_index;
    t_reg_numbering;
    t_hold;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule